// File: doc/BRIEF.md
# SPI Register-Access Target Decoder

This block is an SPI subordinate that lets a host controller read and write words in a register space held elsewhere on the chip. Each frame is framed by chip select and carries a 24-bit header, most significant bit first: an 8-bit command byte and then a 16-bit register address. The command byte holds a 4-bit chip identity, a 2-bit instance identity and a 2-bit opcode. The block compares the two identities with its strapped values. If they do not match, or if the opcode is reserved, the block ignores the rest of the frame.

A read raises a single-cycle read strobe toward the register bus once the header is complete. The returned word is then shifted out on MISO while the host keeps clocking. A write collects the payload and raises a single-cycle write strobe only after the last payload bit arrives. The payload length of each register comes from a per-address table. Addresses that are not in the table use the default length, read back as zero and drop writes without any strobe.

The SPI pins are sampled by the system clock through synchronisers, and all decoding and the register bus run in that clock domain. The serial clock must therefore be slow enough that each SCLK half period spans at least 8 system clock cycles.

Top module: `spi_reg_target`

## Requirements
- R1: A frame with a matching chip ID (command bits [7:4], sent first), matching instance ID (bits [3:2]) and opcode 01 (bits [1:0]) writes. After the 16-bit address and 32 data bits, all sent MSB first, exactly one reg_wr pulse occurs, carrying that address and data.
- R2: A frame whose chip ID field differs from strap_chip_id gives no reg_rd or reg_wr pulse, and spi_miso_oe stays low for the whole frame.
- R3: A frame whose instance ID field differs from strap_mc_id gives no strobe, and spi_miso_oe stays low.
- R4: A frame whose opcode has bit [1] set (10 or 11) is reserved. It gives no strobe, and spi_miso_oe stays low.
- R5: A matching frame with opcode 00 to a mapped address gives exactly one reg_rd pulse carrying that address, after the header completes. The word returned on reg_rdata one cycle later is driven on spi_miso MSB first, with spi_miso_oe high. Each bit is valid at the rising SCLK edge where the host samples it, and spi_miso changes only after a falling SCLK edge.
- R6: Raising CS_N before the last payload bit aborts the frame. No write is committed, and the next frame is decoded from its first bit.
- R7: A read of an unmapped address drives 32 zero bits with spi_miso_oe high and no reg_rd. A write to an unmapped address gives no reg_wr.
- R8: SCLK edges after the payload in the same frame are ignored, and one frame gives at most one strobe.
- R9: After reset, reg_wr, reg_rd and spi_miso_oe are low.
- R10: spi_miso_oe is low whenever CS_N is high, apart from the synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_chip_id | input | 4 | Strapped chip identity |
| strap_mc_id | input | 2 | Strapped instance identity |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso, low means high impedance |
| reg_addr | output | 16 | Register bus address |
| reg_wdata | output | 32 | Register bus write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 32 | Read data, valid the cycle after reg_rd |

## Verification
The assertions check the properties that hold on every cycle. Each strobe lasts one cycle. A write commits only when the bit counter equals the header plus the payload length. spi_miso changes only after a detected falling edge. The output enable drops once select is released, and the counter never runs past the longest frame. What a given frame does depends on its command fields, its address, where it is aborted and how much it overruns. Only the bench scenarios can show this: mismatched identities, reserved opcodes, aborted writes with a read-back, unmapped accesses and overlong frames, each compared with the bench's register model and expected bit stream.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = 16;
    localparam int HDR_W  = CMD_W + ADDR_W;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_LOOK,
        ST_RD_STB,
        ST_RD_CAP,
        ST_RD_OUT,
        ST_WR,
        ST_WR_COMMIT,
        ST_DONE,
        ST_DROP
    } frame_st_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);

    typedef struct packed {
        logic [SYNC_STAGES:0]   sclk;
        logic [SYNC_STAGES-1:0] cs_n;
        logic [SYNC_STAGES-1:0] mosi;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d      = pin_q;
        pin_d.sclk = {pin_q.sclk[SYNC_STAGES-1:0], sclk};
        pin_d.cs_n = {pin_q.cs_n[SYNC_STAGES-2:0], cs_n};
        pin_d.mosi = {pin_q.mosi[SYNC_STAGES-2:0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q.sclk <= '0;
            pin_q.cs_n <= '1;
            pin_q.mosi <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign sclk_rise = pin_q.sclk[SYNC_STAGES-1] & ~pin_q.sclk[SYNC_STAGES];
    assign sclk_fall = ~pin_q.sclk[SYNC_STAGES-1] & pin_q.sclk[SYNC_STAGES];
    assign cs_active = ~pin_q.cs_n[SYNC_STAGES-1];
    assign mosi_s    = pin_q.mosi[SYNC_STAGES-1];

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall)); // R5

endmodule

// File: rtl/spi_reg_map.sv
module spi_reg_map #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1),
    parameter int N_REGS = 2,
    parameter logic [N_REGS-1:0][15:0]      REG_ADDRS = {16'h9104, 16'h9004},
    parameter logic [N_REGS-1:0][LEN_W-1:0] REG_LENS  = {N_REGS{LEN_W'(DATA_W)}}
) (
    input  logic [15:0]      addr,
    output logic             hit,
    output logic [LEN_W-1:0] len
);

    logic [N_REGS-1:0] match;

    for (genvar g = 0; g < N_REGS; g++) begin : g_match
        assign match[g] = (addr == REG_ADDRS[g]);
    end

    always_comb begin
        hit = |match;
        len = LEN_W'(DATA_W);
        for (int i = 0; i < N_REGS; i++) begin
            if (match[i]) len = REG_LENS[i];
        end
    end

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_active,
    input  logic              mosi_s,
    input  logic [3:0]        strap_chip_id,
    input  logic [1:0]        strap_mc_id,
    input  logic              map_hit,
    input  logic [LEN_W-1:0]  map_len,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [15:0]       reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              miso,
    output logic              miso_oe
);

    localparam int CNT_W = $clog2(HDR_W + DATA_W + 1);

    typedef struct packed {
        frame_st_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [CMD_W-1:0]   cmd;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdat;
        logic [DATA_W-1:0]  tx;
        logic [LEN_W-1:0]   len;
        logic               hit;
        logic               miso;
    } frm_t;

    frm_t frm_d, frm_q;

    logic [CMD_W-1:0] cmd_nx;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] wr_total;
    logic             hdr_bad;

    always_comb begin
        cmd_nx   = {frm_q.cmd[CMD_W-2:0], mosi_s};
        cnt_inc  = frm_q.cnt + 1'b1;
        wr_total = CNT_W'(HDR_W) + CNT_W'(frm_q.len);
        hdr_bad  = (cmd_nx[7:4] != strap_chip_id) ||
                   (cmd_nx[3:2] != strap_mc_id)   ||
                   cmd_nx[1];

        frm_d = frm_q;

        if (!cs_active && frm_q.st != ST_WR_COMMIT) begin
            frm_d.st  = ST_IDLE;
            frm_d.cnt = '0;
        end else begin
            unique case (frm_q.st)
                ST_IDLE, ST_HDR: begin
                    frm_d.st = ST_HDR;
                    if (frm_q.st == ST_IDLE) frm_d.cnt = '0;
                    if (sclk_rise) begin
                        frm_d.cnt = (frm_q.st == ST_IDLE) ? CNT_W'(1) : cnt_inc;
                        if (frm_q.st == ST_IDLE || frm_q.cnt < CNT_W'(CMD_W)) begin
                            frm_d.cmd = cmd_nx;
                        end else begin
                            frm_d.addr = {frm_q.addr[ADDR_W-2:0], mosi_s};
                        end
                        if (frm_q.st == ST_HDR && frm_q.cnt == CNT_W'(CMD_W - 1) && hdr_bad) begin
                            frm_d.st = ST_DROP;
                        end
                        if (frm_q.st == ST_HDR && frm_q.cnt == CNT_W'(HDR_W - 1)) begin
                            frm_d.st = ST_LOOK;
                        end
                    end
                end
                ST_LOOK: begin
                    frm_d.hit = map_hit;
                    frm_d.len = map_len;
                    if (frm_q.cmd[1:0] == OP_WRITE) begin
                        frm_d.wdat = '0;
                        frm_d.st   = ST_WR;
                    end else if (map_hit) begin
                        frm_d.st = ST_RD_STB;
                    end else begin
                        frm_d.tx = '0;
                        frm_d.st = ST_RD_OUT;
                    end
                end
                ST_RD_STB: begin
                    frm_d.st = ST_RD_CAP;
                end
                ST_RD_CAP: begin
                    frm_d.tx = reg_rdata << (DATA_W - int'(frm_q.len));
                    frm_d.st = ST_RD_OUT;
                end
                ST_RD_OUT: begin
                    if (sclk_fall) begin
                        frm_d.miso = frm_q.tx[DATA_W-1];
                        frm_d.tx   = frm_q.tx << 1;
                    end
                end
                ST_WR: begin
                    if (sclk_rise) begin
                        frm_d.wdat = {frm_q.wdat[DATA_W-2:0], mosi_s};
                        frm_d.cnt  = cnt_inc;
                        if (cnt_inc == wr_total) begin
                            frm_d.st = frm_q.hit ? ST_WR_COMMIT : ST_DONE;
                        end
                    end
                end
                ST_WR_COMMIT: begin
                    frm_d.st = cs_active ? ST_DONE : ST_IDLE;
                    if (!cs_active) frm_d.cnt = '0;
                end
                ST_DONE, ST_DROP: begin
                    frm_d.st = frm_q.st;
                end
                default: begin
                    frm_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q.st   <= ST_IDLE;
            frm_q.cnt  <= '0;
            frm_q.cmd  <= '0;
            frm_q.addr <= '0;
            frm_q.wdat <= '0;
            frm_q.tx   <= '0;
            frm_q.len  <= '0;
            frm_q.hit  <= 1'b0;
            frm_q.miso <= 1'b0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign reg_addr  = frm_q.addr;
    assign reg_wdata = frm_q.wdat;
    assign reg_rd    = (frm_q.st == ST_RD_STB);
    assign reg_wr    = (frm_q.st == ST_WR_COMMIT);
    assign miso      = frm_q.miso;
    assign miso_oe   = (frm_q.st == ST_RD_OUT);

    AST_WR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (frm_q.cnt == wr_total)); // R6
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R8
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R5
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && !sclk_fall) |=> $stable(miso)); // R5
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !miso_oe); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.cnt <= CNT_W'(HDR_W + DATA_W)); // R8

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target #(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = $clog2(DATA_W + 1),
    parameter int SYNC_STAGES = 2,
    parameter int N_REGS      = 2,
    parameter logic [N_REGS-1:0][15:0]      REG_ADDRS = {16'h9104, 16'h9004},
    parameter logic [N_REGS-1:0][LEN_W-1:0] REG_LENS  = {N_REGS{LEN_W'(DATA_W)}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        strap_chip_id,
    input  logic [1:0]        strap_mc_id,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [15:0]       reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic             sclk_rise;
    logic             sclk_fall;
    logic             cs_active;
    logic             mosi_s;
    logic             map_hit;
    logic [LEN_W-1:0] map_len;

    spi_pin_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_reg_map #(
        .DATA_W    (DATA_W),
        .LEN_W     (LEN_W),
        .N_REGS    (N_REGS),
        .REG_ADDRS (REG_ADDRS),
        .REG_LENS  (REG_LENS)
    ) u_map (
        .addr (reg_addr),
        .hit  (map_hit),
        .len  (map_len)
    );

    spi_frame_ctrl #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_rise     (sclk_rise),
        .sclk_fall     (sclk_fall),
        .cs_active     (cs_active),
        .mosi_s        (mosi_s),
        .strap_chip_id (strap_chip_id),
        .strap_mc_id   (strap_mc_id),
        .map_hit       (map_hit),
        .map_len       (map_len),
        .reg_rdata     (reg_rdata),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .miso          (spi_miso),
        .miso_oe       (spi_miso_oe)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R8

endmodule

// File: tb/sim_spi_reg_target.sv
module sim_spi_reg_target;

    localparam int HALF = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_chip_id = 4'b0001;
    logic [1:0]  strap_mc_id = 2'b10;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_tag = "R9";

    logic [31:0] bank [2];
    logic [15:0] exp_wa [$];
    logic [31:0] exp_wd [$];
    logic [15:0] exp_ra [$];

    always #4 clk = ~clk;

    spi_reg_target u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_chip_id (strap_chip_id),
        .strap_mc_id   (strap_mc_id),
        .spi_sclk      (spi_sclk),
        .spi_cs_n      (spi_cs_n),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .spi_miso_oe   (spi_miso_oe),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_rdata     (reg_rdata)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int bank_idx(input logic [15:0] a);
        if (a == 16'h9004) return 0;
        if (a == 16'h9104) return 1;
        return -1;
    endfunction

    // Behavioural register bank: read data one cycle after reg_rd
    always @(posedge clk) begin
        if (reg_rd) reg_rdata <= (bank_idx(reg_addr) >= 0) ? bank[bank_idx(reg_addr)] : 32'h0;
        if (reg_wr && bank_idx(reg_addr) >= 0) bank[bank_idx(reg_addr)] <= reg_wdata;
    end

    // Per-clock strobe comparison against the expected queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_wa.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected reg_wr at addr", {16'h0, reg_addr}, 32'h0);
                end else begin
                    chk(reg_addr == exp_wa[0], cur_tag, "write addr", {16'h0, reg_addr}, {16'h0, exp_wa[0]});
                    chk(reg_wdata == exp_wd[0], cur_tag, "write data", reg_wdata, exp_wd[0]);
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                end
            end
            if (reg_rd) begin
                if (exp_ra.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected reg_rd at addr", {16'h0, reg_addr}, 32'h0);
                end else begin
                    chk(reg_addr == exp_ra[0], cur_tag, "read addr", {16'h0, reg_addr}, {16'h0, exp_ra[0]});
                    void'(exp_ra.pop_front());
                end
            end
        end
    end

    function automatic logic [7:0] mk_cmd(input logic [3:0] chip, input logic [1:0] mc,
                                          input logic [1:0] op);
        return {chip, mc, op};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame of nbits; checks MISO during the data phase
    task automatic frame(input logic [7:0] cmd, input logic [15:0] addr,
                         input logic [31:0] data, input int nbits,
                         input logic exp_oe, input logic [31:0] exp_rd,
                         input string tag);
        int bad_bits = 0;
        logic [31:0] got = '0;
        cur_tag = tag;
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8)        spi_mosi = cmd[7-i];
            else if (i < 24)  spi_mosi = addr[23-i];
            else if (i < 56)  spi_mosi = data[55-i];
            else              spi_mosi = 1'b0;
            wait_clk(HALF);
            if (i >= 24 && i < 56) begin
                got[55-i] = spi_miso;
                if (spi_miso_oe !== exp_oe) bad_bits++;
                if (exp_oe && spi_miso !== exp_rd[55-i]) bad_bits++;
            end else if (i < 24 && spi_miso_oe !== 1'b0) begin
                bad_bits++;
            end
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        if (nbits >= 56) begin
            chk(bad_bits == 0, tag, exp_oe ? "MISO data phase" : "MISO held off",
                exp_oe ? got : {31'h0, spi_miso_oe}, exp_oe ? exp_rd : 32'h0);
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(4 * HALF);
        chk(exp_wa.size() == 0 && exp_ra.size() == 0, tag, "missing strobe count",
            exp_wa.size() + exp_ra.size(), 32'h0);
        chk(spi_miso_oe == 1'b0, "R10", "oe after CS high", {31'h0, spi_miso_oe}, 32'h0);
    endtask

    localparam logic [3:0] CHIP = 4'b0001;
    localparam logic [1:0] MC   = 2'b10;

    initial begin
        bank[0] = 32'h0;
        bank[1] = 32'h0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk(!reg_wr && !reg_rd && !spi_miso_oe, "R9", "reset outputs",
            {29'h0, reg_wr, reg_rd, spi_miso_oe}, 32'h0);

        // R1: matching write
        exp_wa.push_back(16'h9004); exp_wd.push_back(32'hA5C3_1E7F);
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9004, 32'hA5C3_1E7F, 56, 1'b0, 0, "R1");
        exp_wa.push_back(16'h9104); exp_wd.push_back(32'h0123_4567);
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9104, 32'h0123_4567, 56, 1'b0, 0, "R1");

        // R5: reads of mapped registers
        exp_ra.push_back(16'h9004);
        frame(mk_cmd(CHIP, MC, 2'b00), 16'h9004, 0, 56, 1'b1, 32'hA5C3_1E7F, "R5");
        exp_ra.push_back(16'h9104);
        frame(mk_cmd(CHIP, MC, 2'b00), 16'h9104, 0, 56, 1'b1, 32'h0123_4567, "R5");

        // R2: chip ID mismatch, write and read both ignored
        frame(mk_cmd(4'b0100, MC, 2'b01), 16'h9004, 32'hFFFF_FFFF, 56, 1'b0, 0, "R2");
        frame(mk_cmd(4'b0000, MC, 2'b00), 16'h9004, 0, 56, 1'b0, 0, "R2");
        // R3: instance ID mismatch
        frame(mk_cmd(CHIP, 2'b01, 2'b00), 16'h9104, 0, 56, 1'b0, 0, "R3");
        frame(mk_cmd(CHIP, 2'b11, 2'b01), 16'h9104, 32'hDEAD_BEEF, 56, 1'b0, 0, "R3");
        // R4: reserved opcodes
        frame(mk_cmd(CHIP, MC, 2'b10), 16'h9004, 32'h1111_2222, 56, 1'b0, 0, "R4");
        frame(mk_cmd(CHIP, MC, 2'b11), 16'h9004, 32'h3333_4444, 56, 1'b0, 0, "R4");
        // ignored frames left the register intact
        exp_ra.push_back(16'h9004);
        frame(mk_cmd(CHIP, MC, 2'b00), 16'h9004, 0, 56, 1'b1, 32'hA5C3_1E7F, "R2");

        // R6: abort in data phase, then abort in header
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9104, 32'hCAFE_F00D, 40, 1'b0, 0, "R6");
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9104, 32'hCAFE_F00D, 55, 1'b0, 0, "R6");
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9104, 32'hCAFE_F00D, 10, 1'b0, 0, "R6");
        exp_ra.push_back(16'h9104);
        frame(mk_cmd(CHIP, MC, 2'b00), 16'h9104, 0, 56, 1'b1, 32'h0123_4567, "R6");
        exp_wa.push_back(16'h9104); exp_wd.push_back(32'h5A5A_0F0F);
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9104, 32'h5A5A_0F0F, 56, 1'b0, 0, "R6");

        // R7: unmapped read returns zeros, unmapped write has no strobe
        frame(mk_cmd(CHIP, MC, 2'b00), 16'h1234, 0, 56, 1'b1, 32'h0, "R7");
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9008, 32'h7777_8888, 56, 1'b0, 0, "R7");

        // R8: overlong frames give a single strobe
        exp_wa.push_back(16'h9004); exp_wd.push_back(32'h8000_0001);
        frame(mk_cmd(CHIP, MC, 2'b01), 16'h9004, 32'h8000_0001, 64, 1'b0, 0, "R8");
        exp_ra.push_back(16'h9004);
        frame(mk_cmd(CHIP, MC, 2'b00), 16'h9004, 0, 64, 1'b1, 32'h8000_0001, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired during %s: actual 1 expected 0", cur_tag);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule